// File: doc/BRIEF.md
# Program Counter with Return Stack

This block generates instruction fetch addresses for a small microcontroller core. It keeps a 13-bit program counter, which spans a logical space of 8k words. Only 2k words of program memory exist, so the fetch address it presents is always folded into that physical range. An eight-level hardware stack of return addresses sits beside the counter, and subroutine calls and interrupt entry use it.

Each cycle the core raises some mix of single-cycle requests: advance to the next word, jump to a target, call a target, return, or take an interrupt. A synchronous reset overrides all of them. A fixed priority picks one action. The counter then takes its new value at the clock edge, and the fetch address follows it.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the counter becomes 0000h and all eight stack slots are cleared to zero. A return taken straight after reset therefore fetches from 0000h.
- R2: A cycle with only `step_en` high adds one to the 13-bit counter. `fetch_addr` is the low 11 bits of the counter, so the fetch address goes from 07FFh to 0000h, and past 1FFFh the counter itself goes back to 0000h.
- R3: `jump_en` loads the full 13-bit `tgt_addr` into the counter, and `fetch_addr` then equals `tgt_addr` modulo 2048.
- R4: `call_en` loads `tgt_addr` and pushes the counter plus one as a full 13-bit value. The matching return resumes at that value.
- R5: `irq_take` loads the counter with 0004h and pushes the counter plus one, in the same way as a call.
- R6: `ret_en` pops the most recent entry into the counter. Nested calls up to eight deep return in last-in, first-out order.
- R7: A ninth push with no pop in between overwrites the oldest entry, so the stack works as a ring. After nine calls, eight returns give the return addresses of calls 9 down to 2, and a ninth return gives the address of call 9 again. No flag is raised.
- R8: When several requests come in one cycle, only one acts. The order is reset first, then interrupt, then call or jump (a call wins over a jump), then return, then step.
- R9: A cycle with no request leaves the counter and the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_take | input | 1 | Interrupt accepted this cycle |
| step_en | input | 1 | Advance to the next word |
| jump_en | input | 1 | Load `tgt_addr` without pushing |
| call_en | input | 1 | Load `tgt_addr` and push the return address |
| ret_en | input | 1 | Pop the stack into the counter |
| tgt_addr | input | 13 | Jump or call target |
| fetch_addr | output | 11 | Physical program memory address |

## Verification
The hardest state to reach is a wrapped ring, where the write pointer has passed the oldest entry. A return then gives back an overwritten slot, and the pop sequence closes on itself. The bench gets there with chains of calls of every depth from one to nine, each to a distinct target above and below the 2k fold. It then unwinds each chain and compares every landing address with sums worked out in the bench. Requests are also raised together in one cycle, and the return that follows shows whether the losing request touched the stack.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;

    localparam int DEF_PC_W    = 13;
    localparam int DEF_PHYS_W  = 11;
    localparam int DEF_STK_DEP = 8;
    localparam int RESET_VEC   = 0;
    localparam int IRQ_VEC     = 4;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STEP,
        OP_RET,
        OP_JUMP,
        OP_CALL,
        OP_IRQ,
        OP_RESET
    } pc_op_e;

    typedef struct packed {
        pc_op_e op;
        logic   push;
        logic   pop;
    } pc_cmd_t;

    // Fixed priority: reset, interrupt, call, jump, return, step.
    function automatic pc_op_e pick_op(input logic rst, input logic irq,
                                       input logic call, input logic jump,
                                       input logic ret, input logic step);
        pc_op_e r;
        if (rst)       r = OP_RESET;
        else if (irq)  r = OP_IRQ;
        else if (call) r = OP_CALL;
        else if (jump) r = OP_JUMP;
        else if (ret)  r = OP_RET;
        else if (step) r = OP_STEP;
        else           r = OP_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/pc_cmd_arb.sv
module pc_cmd_arb
    import pcgen_pkg::*;
(
    input  logic    rst,
    input  logic    irq_take,
    input  logic    step_en,
    input  logic    jump_en,
    input  logic    call_en,
    input  logic    ret_en,
    output pc_cmd_t cmd
);

    always_comb begin
        cmd.op   = pick_op(rst, irq_take, call_en, jump_en, ret_en, step_en);
        cmd.push = (cmd.op == OP_IRQ) || (cmd.op == OP_CALL);
        cmd.pop  = (cmd.op == OP_RET);
    end

endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int WIDTH = 13,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [WIDTH-1:0] slot [DEPTH];

    // The most recent entry sits one below the write pointer; the pointer wraps as a ring.
    always_comb begin
        rd_ptr = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end else if (pop) begin
            wr_ptr <= rd_ptr;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (push && (wr_ptr == PTR_W'(g))) begin
                slot[g] <= push_data;
            end
        end
    end

    assign top_data = slot[rd_ptr];

endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
    import pcgen_pkg::*;
#(
    parameter int PC_W = 13
) (
    input  pc_cmd_t         cmd,
    input  logic [PC_W-1:0] pc_q,
    input  logic [PC_W-1:0] tgt_addr,
    input  logic [PC_W-1:0] stk_top,
    output logic [PC_W-1:0] pc_d,
    output logic [PC_W-1:0] ret_addr
);

    logic [PC_W-1:0] pc_inc;

    always_comb begin
        pc_inc   = pc_q + 1'b1;
        ret_addr = pc_inc;
        unique case (cmd.op)
            OP_RESET: pc_d = PC_W'(RESET_VEC);
            OP_IRQ:   pc_d = PC_W'(IRQ_VEC);
            OP_CALL,
            OP_JUMP:  pc_d = tgt_addr;
            OP_RET:   pc_d = stk_top;
            OP_STEP:  pc_d = pc_inc;
            default:  pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pcgen_pkg::*;
#(
    parameter int PC_W    = DEF_PC_W,
    parameter int PHYS_W  = DEF_PHYS_W,
    parameter int STK_DEP = DEF_STK_DEP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_take,
    input  logic              step_en,
    input  logic              jump_en,
    input  logic              call_en,
    input  logic              ret_en,
    input  logic [PC_W-1:0]   tgt_addr,
    output logic [PHYS_W-1:0] fetch_addr
);

    pc_cmd_t         cmd;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] ret_addr;
    logic [PC_W-1:0] stk_top;

    pc_cmd_arb u_arb (
        .rst      (rst),
        .irq_take (irq_take),
        .step_en  (step_en),
        .jump_en  (jump_en),
        .call_en  (call_en),
        .ret_en   (ret_en),
        .cmd      (cmd)
    );

    pc_ret_stack #(
        .WIDTH (PC_W),
        .DEPTH (STK_DEP)
    ) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (cmd.push),
        .pop       (cmd.pop),
        .push_data (ret_addr),
        .top_data  (stk_top)
    );

    pc_next_mux #(
        .PC_W (PC_W)
    ) u_mux (
        .cmd      (cmd),
        .pc_q     (pc_q),
        .tgt_addr (tgt_addr),
        .stk_top  (stk_top),
        .pc_d     (pc_d),
        .ret_addr (ret_addr)
    );

    always_ff @(posedge clk) begin
        pc_q <= pc_d;
    end

    // Folding onto the physical memory: keep only the low bits.
    assign fetch_addr = pc_q[PHYS_W-1:0];

endmodule

// File: rtl/pc_seq_unit_chk.sv
module pc_seq_unit_chk #(
    parameter int PC_W   = 13,
    parameter int PHYS_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_take,
    input logic              step_en,
    input logic              jump_en,
    input logic              call_en,
    input logic              ret_en,
    input logic [PC_W-1:0]   tgt_addr,
    input logic [PHYS_W-1:0] fetch_addr
);

    logic quiet;
    logic only_step;
    logic only_ret;
    logic only_call;
    logic past_valid;

    assign quiet     = !irq_take && !step_en && !jump_en && !call_en && !ret_en;
    assign only_step = step_en && !irq_take && !jump_en && !call_en && !ret_en;
    assign only_ret  = ret_en && !irq_take && !jump_en && !call_en;
    assign only_call = call_en && !irq_take;

    always_ff @(posedge clk) begin
        past_valid <= !rst;
    end

    AST_RESET_VECTOR: assert property (@(posedge clk)
        rst |=> fetch_addr == '0); // R1

    AST_STEP_FOLD: assert property (@(posedge clk) disable iff (rst)
        only_step |=> fetch_addr == PHYS_W'($past(fetch_addr) + 1'b1)); // R2

    AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && (jump_en || call_en)) |=> fetch_addr == $past(tgt_addr[PHYS_W-1:0])); // R3

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> fetch_addr == PHYS_W'(4)); // R5

    AST_CALL_RETURN: assert property (@(posedge clk) disable iff (rst)
        (past_valid && only_ret && $past(only_call))
            |=> fetch_addr == PHYS_W'($past(fetch_addr, 2) + 1'b1)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        quiet |=> $stable(fetch_addr)); // R9

endmodule

bind pc_seq_unit pc_seq_unit_chk #(
    .PC_W   (PC_W),
    .PHYS_W (PHYS_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_take   (irq_take),
    .step_en    (step_en),
    .jump_en    (jump_en),
    .call_en    (call_en),
    .ret_en     (ret_en),
    .tgt_addr   (tgt_addr),
    .fetch_addr (fetch_addr)
);

// File: tb/pc_seq_unit_tb.sv
`timescale 1ns/1ps
module pc_seq_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_take = 1'b0;
    logic        step_en = 1'b0;
    logic        jump_en = 1'b0;
    logic        call_en = 1'b0;
    logic        ret_en = 1'b0;
    logic [12:0] tgt_addr = '0;
    logic [10:0] fetch_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pc_seq_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .irq_take   (irq_take),
        .step_en    (step_en),
        .jump_en    (jump_en),
        .call_en    (call_en),
        .ret_en     (ret_en),
        .tgt_addr   (tgt_addr),
        .fetch_addr (fetch_addr)
    );

    task automatic check(input string req, input int expv);
        checks++;
        if (int'(fetch_addr) != (expv & 16'h7FF)) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, fetch_addr, expv & 16'h7FF);
        end
    endtask

    // Sets the requests at a falling edge and returns at the next falling edge.
    task automatic cyc(input bit r, input bit i, input bit c, input bit j,
                       input bit rt, input bit s, input int t);
        rst = r; irq_take = i; call_en = c; jump_en = j; ret_en = rt; step_en = s;
        tgt_addr = 13'(t);
        @(negedge clk);
        rst = 0; irq_take = 0; call_en = 0; jump_en = 0; ret_en = 0; step_en = 0;
    endtask

    task automatic do_reset();
        cyc(1, 0, 0, 0, 0, 0, 0);
    endtask

    function automatic int call_tgt(input int k, input int d);
        return (k * 16'h3A5 + d * 16'h111 + 16'h800) & 16'h1FFF;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pc_m;
        @(negedge clk);
        do_reset();
        check("R1 reset vector", 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R1 cleared stack return", 0);

        // R2: step sweep across the physical fold
        do_reset();
        for (int i = 1; i <= 2100; i++) begin
            cyc(0, 0, 0, 0, 0, 1, 0);
            check("R2 step", i);
        end
        // R2: logical counter rolls over past 1FFFh
        cyc(0, 0, 0, 1, 0, 0, 16'h1FFE);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R2 step 1FFF", 16'h1FFF);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R2 step rollover", 0);

        // R3: jump sweep over the logical space
        for (int t = 0; t < 8192; t += 61) begin
            cyc(0, 0, 0, 1, 0, 0, t);
            check("R3 jump", t);
        end

        // R9: idle cycles hold, stack untouched
        cyc(0, 0, 0, 1, 0, 0, 16'h0ABC);
        cyc(0, 0, 1, 0, 0, 0, 16'h0123);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 0, 0, 0, 0, 16'h1777);
            check("R9 idle hold", 16'h0123);
        end
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R9 stack kept", 16'h0ABD);

        // R4/R6: nested call chains of depth 1..8
        for (int d = 1; d <= 8; d++) begin
            do_reset();
            for (int k = 0; k < d; k++) begin
                cyc(0, 0, 1, 0, 0, 0, call_tgt(k, d));
                check("R4 call target", call_tgt(k, d));
            end
            for (int k = d - 1; k >= 0; k--) begin
                pc_m = (k == 0) ? 0 : call_tgt(k - 1, d);
                cyc(0, 0, 0, 0, 1, 0, 0);
                check("R6 nested return", pc_m + 1);
            end
        end

        // R7: nine pushes wrap the ring
        do_reset();
        for (int k = 0; k < 9; k++) begin
            cyc(0, 0, 1, 0, 0, 0, call_tgt(k, 9));
        end
        for (int k = 8; k >= 1; k--) begin
            cyc(0, 0, 0, 0, 1, 0, 0);
            check("R7 ring pop", call_tgt(k - 1, 9) + 1);
        end
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R7 ring repeat", call_tgt(7, 9) + 1);

        // R5: interrupt entry and return
        do_reset();
        cyc(0, 0, 0, 1, 0, 0, 16'h1555);
        cyc(0, 1, 0, 0, 0, 0, 0);
        check("R5 irq vector", 4);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R5 handler step", 5);
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R5 irq return", 16'h1556);

        // R8: priority among simultaneous requests
        do_reset();
        cyc(0, 0, 0, 1, 0, 0, 16'h200);
        cyc(0, 1, 1, 1, 1, 1, 16'h777);
        check("R8 irq over all", 4);
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R8 irq pushed", 16'h201);
        cyc(0, 0, 0, 1, 0, 0, 16'h300);
        cyc(0, 0, 1, 1, 0, 0, 16'h040);
        check("R8 call over jump", 16'h040);
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R8 call pushed", 16'h301);
        cyc(0, 0, 1, 0, 1, 0, 16'h050);
        check("R8 call over ret", 16'h050);
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R8 ret after call", 16'h302);
        cyc(0, 0, 0, 1, 0, 0, 16'h600);
        cyc(0, 0, 1, 0, 0, 0, 16'h010);
        cyc(0, 0, 0, 0, 1, 1, 0);
        check("R8 ret over step", 16'h601);
        cyc(0, 0, 0, 1, 0, 1, 16'h0AA);
        check("R8 jump over step", 16'h0AA);
        cyc(1, 1, 1, 0, 1, 1, 16'h123);
        check("R8 reset over all", 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule